// File: doc/BRIEF.md
# Real-Time Clock with Wake Alarms

This block keeps time for a system that may be powered down. A slow 32 kHz clock enable is divided down to one pulse per second. That pulse drives a seconds counter, which counts 0 to 59, and a 24-bit minute counter. Software reaches the block through a byte-wide port: one write strobe, a 4-bit address, write data, and a combinational read-back.

The block produces two kinds of event:
- A periodic repeat pulse, at an interval chosen from four options.
- An alarm pulse, when the running time equals a programmed alarm time. The alarm is four bytes long. Bytes are held in a staging area and become active together only when the top minute byte is written.

When the system reports that it is powered off, either event can be turned into a wake request. Each event has its own enable for this.

Top module: `rtc_alarm_core`

## Requirements
- R1: After reset, the registers read as follows: control, seconds and the three minute bytes read 00h; alarm seconds reads 3Fh; each alarm minute byte reads FFh. All three event outputs are low.
- R2: Control bit 0 is the run enable. While it is 0, the seconds and minute counters hold their values.
- R3: Each time the prescaler counts PRESC_DIV accepted pulses of `tick32k_i`, the seconds counter advances by one. A pulse is accepted only while the run enable is set. Writing the seconds register clears the prescaler.
- R4: The seconds counter advances from 59, or from any written value above 59, to 0. On that step the 24-bit minute counter increments, and it wraps from FFFFFFh to 000000h.
- R5: Control bits 2:1 select the repeat interval: 0 = every second, 1 = each minute, 2 = every second minute (new minute even), 3 = every eighth minute (new minute a multiple of 8). The pulse comes on `rep_irq_o` for one cycle. It appears in the same cycle as the new time, and only on a seconds advance.
- R6: The register addresses are: 0 control, 1 seconds, 2/3/4 minute bytes low/middle/high, 5 alarm seconds, 6/7/8 alarm minute bytes low/middle/high. Other addresses read 00h. Writes to addresses 5 to 7 go only to staging storage, and reads of 5 to 8 return the active alarm. Writing address 8 activates all four bytes at once.
- R7: `alarm_irq_o` pulses for one cycle when the time becomes equal to the active alarm in both seconds and all 24 minute bits. The reset alarm never matches.
- R8: `wake_o` follows this expression: `sys_off_i` and ((`rep_irq_o` and control bit 4) or (`alarm_irq_o` and control bit 3)).
- R9: A write to any time register in a cycle blocks the seconds advance in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick32k_i | input | 1 | 32 kHz clock enable, one cycle per pulse |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` |
| sys_off_i | input | 1 | System is powered off |
| rep_irq_o | output | 1 | Repeat event pulse |
| alarm_irq_o | output | 1 | Alarm match pulse |
| wake_o | output | 1 | Qualified wake request pulse |

## Verification
Most internal faults show up in the repeat pulse count, which is sampled every second. This applies to a wrong prescaler count, a missing prescaler clear, or a wrong wrap point. Any of these shifts the repeat count, or the seconds read-back, within one second of the fault.

A staging fault shows up on the very next read of the alarm bytes, because reads return the active alarm and not the staged bytes. A wrong match compare, or a broken edge detect, shows up as an alarm pulse count other than exactly one across the alarm second.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned MIN_BYTES = 3;
  localparam int unsigned MIN_W     = BYTE_W * MIN_BYTES;
  localparam int unsigned ALM_BYTES = MIN_BYTES + 1;
  localparam logic [BYTE_W-1:0] SEC_LAST = 8'd59;

  typedef enum logic [3:0] {
    A_CTRL  = 4'd0,
    A_SEC   = 4'd1,
    A_MIN0  = 4'd2,
    A_MIN1  = 4'd3,
    A_MIN2  = 4'd4,
    A_ASEC  = 4'd5,
    A_AMIN0 = 4'd6,
    A_AMIN1 = 4'd7,
    A_AMIN2 = 4'd8
  } rtc_addr_e;

  typedef enum logic [1:0] {
    REP_SEC  = 2'd0,
    REP_MIN  = 2'd1,
    REP_2MIN = 2'd2,
    REP_8MIN = 2'd3
  } rep_sel_e;

  localparam int unsigned CTRL_W       = 5;
  localparam int unsigned CTRL_RUN     = 0;
  localparam int unsigned CTRL_REP_LSB = 1;
  localparam int unsigned CTRL_ALM_WK  = 3;
  localparam int unsigned CTRL_REP_WK  = 4;
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int unsigned DIV = 32768
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic tick_i,
  input  logic clr_i,
  output logic sec_tick_o
);
  localparam int unsigned CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clr_i)             cnt_q <= '0;
    else if (run_i && tick_i)   cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  assign sec_tick_o = run_i && tick_i && (cnt_q == LAST) && !clr_i;
endmodule

// File: rtl/rtc_timebase.sv
module rtc_timebase
  import rtc_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 adv_i,
  input  logic                 sec_we_i,
  input  logic [MIN_BYTES-1:0] min_we_i,
  input  logic [BYTE_W-1:0]    wdata_i,
  output logic [BYTE_W-1:0]    sec_o,
  output logic [MIN_W-1:0]     min_o,
  output logic [BYTE_W-1:0]    sec_nxt_o,
  output logic [MIN_W-1:0]     min_nxt_o
);
  logic [BYTE_W-1:0] sec_q;
  logic [MIN_W-1:0]  min_q;
  logic              wrap;

  // values at or above the last second all wrap
  assign wrap      = (sec_q >= SEC_LAST);
  assign sec_nxt_o = wrap ? '0 : sec_q + 1'b1;
  assign min_nxt_o = wrap ? min_q + 1'b1 : min_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sec_q <= '0;
    else if (sec_we_i) sec_q <= wdata_i;
    else if (adv_i)    sec_q <= sec_nxt_o;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) min_q <= '0;
    else if (|min_we_i) begin
      for (int b = 0; b < MIN_BYTES; b++)
        if (min_we_i[b]) min_q[b*BYTE_W +: BYTE_W] <= wdata_i;
    end else if (adv_i) min_q <= min_nxt_o;
  end

  assign sec_o = sec_q;
  assign min_o = min_q;
endmodule

// File: rtl/rtc_alarm_regs.sv
module rtc_alarm_regs
  import rtc_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [ALM_BYTES-1:0] we_i,
  input  logic [BYTE_W-1:0]    wdata_i,
  output logic [BYTE_W-1:0]    alm_sec_o,
  output logic [MIN_W-1:0]     alm_min_o
);
  localparam logic [BYTE_W-1:0] SEC_RST = 8'h3F;
  localparam logic [BYTE_W-1:0] MIN_RST = 8'hFF;
  localparam int unsigned TOP = ALM_BYTES - 1;

  logic [BYTE_W-1:0] shad_q [TOP];
  logic [BYTE_W-1:0] act_q  [ALM_BYTES];

  for (genvar b = 0; b < TOP; b++) begin : g_stage
    localparam logic [BYTE_W-1:0] RV = (b == 0) ? SEC_RST : MIN_RST;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      shad_q[b] <= RV;
      else if (we_i[b]) shad_q[b] <= wdata_i;
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        act_q[b] <= RV;
      else if (we_i[TOP]) act_q[b] <= shad_q[b];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        act_q[TOP] <= MIN_RST;
    else if (we_i[TOP]) act_q[TOP] <= wdata_i;
  end

  assign alm_sec_o = act_q[0];
  for (genvar b = 1; b < ALM_BYTES; b++) begin : g_out
    assign alm_min_o[(b-1)*BYTE_W +: BYTE_W] = act_q[b];
  end
endmodule

// File: rtl/rtc_alarm_core.sv
module rtc_alarm_core
  import rtc_pkg::*;
#(
  parameter int unsigned PRESC_DIV = 32768
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick32k_i,
  input  logic       wr_en_i,
  input  logic [3:0] addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  input  logic       sys_off_i,
  output logic       rep_irq_o,
  output logic       alarm_irq_o,
  output logic       wake_o
);
  logic [CTRL_W-1:0]    ctrl_q;
  logic                 osc_en;
  rep_sel_e             rep_sel;
  logic                 sec_we;
  logic [MIN_BYTES-1:0] min_we;
  logic [ALM_BYTES-1:0] stage_we;
  logic                 time_wr;
  logic                 raw_tick;
  logic                 sec_tick;
  logic [BYTE_W-1:0]    sec_q, sec_nxt, alm_sec;
  logic [MIN_W-1:0]     min_q, min_nxt, alm_min;
  logic                 rep_cond, rep_q;
  logic                 match, match_q;

  assign osc_en  = ctrl_q[CTRL_RUN];
  assign rep_sel = rep_sel_e'(ctrl_q[CTRL_REP_LSB +: 2]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          ctrl_q <= '0;
    else if (wr_en_i && addr_i == A_CTRL) ctrl_q <= wdata_i[CTRL_W-1:0];
  end

  assign sec_we = wr_en_i && (addr_i == A_SEC);
  for (genvar b = 0; b < MIN_BYTES; b++) begin : g_min_we
    assign min_we[b] = wr_en_i && (addr_i == 4'(A_MIN0 + b));
  end
  for (genvar b = 0; b < ALM_BYTES; b++) begin : g_alm_we
    assign stage_we[b] = wr_en_i && (addr_i == 4'(A_ASEC + b));
  end
  assign time_wr  = sec_we || (|min_we);
  assign sec_tick = raw_tick && !time_wr;

  rtc_prescaler #(.DIV(PRESC_DIV)) u_presc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (osc_en),
    .tick_i     (tick32k_i),
    .clr_i      (sec_we),
    .sec_tick_o (raw_tick)
  );

  rtc_timebase u_time (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .adv_i     (sec_tick),
    .sec_we_i  (sec_we),
    .min_we_i  (min_we),
    .wdata_i   (wdata_i),
    .sec_o     (sec_q),
    .min_o     (min_q),
    .sec_nxt_o (sec_nxt),
    .min_nxt_o (min_nxt)
  );

  rtc_alarm_regs u_alarm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (stage_we),
    .wdata_i   (wdata_i),
    .alm_sec_o (alm_sec),
    .alm_min_o (alm_min)
  );

  // repeat condition judged on the time about to be loaded
  always_comb begin
    unique case (rep_sel)
      REP_SEC:  rep_cond = 1'b1;
      REP_MIN:  rep_cond = (sec_nxt == '0);
      REP_2MIN: rep_cond = (sec_nxt == '0) && !min_nxt[0];
      REP_8MIN: rep_cond = (sec_nxt == '0) && (min_nxt[2:0] == 3'd0);
      default:  rep_cond = 1'b0;
    endcase
  end

  assign match = (sec_q == alm_sec) && (min_q == alm_min);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rep_q   <= 1'b0;
      match_q <= 1'b0;
    end else begin
      rep_q   <= sec_tick && rep_cond;
      match_q <= match;
    end
  end

  assign rep_irq_o   = rep_q;
  assign alarm_irq_o = match && !match_q;
  assign wake_o      = sys_off_i && ((rep_q && ctrl_q[CTRL_REP_WK]) ||
                                     (alarm_irq_o && ctrl_q[CTRL_ALM_WK]));

  always_comb begin
    case (addr_i)
      A_CTRL:  rdata_o = 8'(ctrl_q);
      A_SEC:   rdata_o = sec_q;
      A_MIN0:  rdata_o = min_q[7:0];
      A_MIN1:  rdata_o = min_q[15:8];
      A_MIN2:  rdata_o = min_q[23:16];
      A_ASEC:  rdata_o = alm_sec;
      A_AMIN0: rdata_o = alm_min[7:0];
      A_AMIN1: rdata_o = alm_min[15:8];
      A_AMIN2: rdata_o = alm_min[23:16];
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/rtc_alarm_core_chk.sv
module rtc_alarm_core_chk
  import rtc_pkg::*;
(
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 osc_en,
  input logic                 time_wr,
  input logic                 sec_tick,
  input logic [BYTE_W-1:0]    sec_q,
  input logic [MIN_W-1:0]     min_q,
  input logic [ALM_BYTES-1:0] stage_we,
  input logic [BYTE_W-1:0]    alm_sec,
  input logic [MIN_W-1:0]     alm_min,
  input logic                 sys_off_i,
  input logic                 rep_irq_o,
  input logic                 alarm_irq_o,
  input logic                 wake_o
);
  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!osc_en && !time_wr) |=> ($stable(sec_q) && $stable(min_q)));

  p_stage_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|stage_we[ALM_BYTES-2:0]) |=> ($stable(alm_sec) && $stable(alm_min)));

  p_rep_on_tick_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rep_irq_o |-> $past(sec_tick));

  p_alarm_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alarm_irq_o |=> !alarm_irq_o);

  p_wake_qual_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> (sys_off_i && (rep_irq_o || alarm_irq_o)));

  p_no_adv_on_wr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    time_wr |-> !sec_tick);
endmodule

bind rtc_alarm_core rtc_alarm_core_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .osc_en      (osc_en),
  .time_wr     (time_wr),
  .sec_tick    (sec_tick),
  .sec_q       (sec_q),
  .min_q       (min_q),
  .stage_we    (stage_we),
  .alm_sec     (alm_sec),
  .alm_min     (alm_min),
  .sys_off_i   (sys_off_i),
  .rep_irq_o   (rep_irq_o),
  .alarm_irq_o (alarm_irq_o),
  .wake_o      (wake_o)
);

// File: tb/rtc_alarm_core_tb.sv
module rtc_alarm_core_tb;
  localparam int DIV = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       sys_off = 1'b0;
  logic       rep_irq, alarm_irq, wake;

  int n_chk = 0, n_fail = 0;
  int rep_cnt = 0, alm_cnt = 0, wake_cnt = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rtc_alarm_core #(.PRESC_DIV(DIV)) u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .tick32k_i   (tick),
    .wr_en_i     (wr_en),
    .addr_i      (addr),
    .wdata_i     (wdata),
    .rdata_o     (rdata),
    .sys_off_i   (sys_off),
    .rep_irq_o   (rep_irq),
    .alarm_irq_o (alarm_irq),
    .wake_o      (wake)
  );

  always @(negedge clk) begin
    if (rep_irq)   rep_cnt++;
    if (alarm_irq) alm_cnt++;
    if (wake)      wake_cnt++;
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(posedge clk); #1 wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1 wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output int v);
    @(posedge clk); #1 addr = a;
    @(negedge clk); v = int'(rdata);
  endtask

  task automatic rd_min(output int v);
    int b0, b1, b2;
    rd(4'd2, b0); rd(4'd3, b1); rd(4'd4, b2);
    v = (b2 << 16) | (b1 << 8) | b0;
  endtask

  task automatic tick_sec(input int secs);
    repeat (secs * DIV) begin
      @(posedge clk); #1 tick = 1'b1;
      @(posedge clk); #1 tick = 1'b0;
    end
    repeat (3) @(posedge clk);
  endtask

  task automatic set_time(input int s, input int m);
    wr(4'd1, 8'(s));
    wr(4'd2, 8'(m)); wr(4'd3, 8'(m >> 8)); wr(4'd4, 8'(m >> 16));
  endtask

  function automatic int exp_rep(input int s0, input int m0, input int secs, input int mode);
    int s = s0, m = m0, c = 0;
    for (int i = 0; i < secs; i++) begin
      if (s >= 59) begin s = 0; m = (m + 1) % (1 << 24); end
      else s++;
      case (mode)
        0: c++;
        1: if (s == 0) c++;
        2: if (s == 0 && m % 2 == 0) c++;
        default: if (s == 0 && m % 8 == 0) c++;
      endcase
    end
    return c;
  endfunction

  task automatic report;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      report();
    end
  end

  initial begin
    int v, b_rep, b_alm, b_wake;
    repeat (3) @(posedge clk); #1 rst_n = 1'b1;

    // R1 reset values
    check("R1 rep", int'(rep_irq), 0);
    check("R1 alarm", int'(alarm_irq), 0);
    check("R1 wake", int'(wake), 0);
    for (int a = 0; a < 9; a++) begin
      rd(4'(a), v);
      check($sformatf("R1 addr %0d", a), v, (a == 5) ? 'h3F : (a > 5) ? 'hFF : 0);
    end
    rd(4'd12, v); check("R6 unmapped read", v, 0);

    // R2 hold while run enable clear
    tick_sec(3);
    rd(4'd1, v); check("R2 seconds hold", v, 0);

    // R3 run count and prescaler clear on seconds write
    wr(4'd0, 8'h01);
    tick_sec(7);
    rd(4'd1, v); check("R3 seconds after 7", v, 7);
    repeat (DIV - 1) begin
      @(posedge clk); #1 tick = 1'b1; @(posedge clk); #1 tick = 1'b0;
    end
    wr(4'd1, 8'd10);
    repeat (DIV - 1) begin
      @(posedge clk); #1 tick = 1'b1; @(posedge clk); #1 tick = 1'b0;
    end
    rd(4'd1, v); check("R3 prescaler cleared", v, 10);
    @(posedge clk); #1 tick = 1'b1; @(posedge clk); #1 tick = 1'b0;
    rd(4'd1, v); check("R3 next second", v, 11);

    // R4 wraps
    wr(4'd0, 8'h00);
    set_time(59, 'hFFFFFF);
    wr(4'd0, 8'h01);
    tick_sec(1);
    rd(4'd1, v); check("R4 sec wrap", v, 0);
    rd_min(v);   check("R4 minute wrap", v, 0);
    wr(4'd0, 8'h00);
    set_time(70, 'h000012);
    wr(4'd0, 8'h01);
    tick_sec(1);
    rd(4'd1, v); check("R4 over-range sec", v, 0);
    rd_min(v);   check("R4 minute inc", v, 'h13);

    // R9 write blocks advance: tick on the write cycle itself
    wr(4'd0, 8'h00);
    set_time(20, 0);
    wr(4'd0, 8'h01);
    repeat (DIV - 1) begin
      @(posedge clk); #1 tick = 1'b1; @(posedge clk); #1 tick = 1'b0;
    end
    @(posedge clk); #1 tick = 1'b1; wr_en = 1'b1; addr = 4'd2; wdata = 8'h07;
    @(posedge clk); #1 tick = 1'b0; wr_en = 1'b0;
    rd(4'd1, v); check("R9 no advance on write", v, 20);

    // R5 repeat intervals
    for (int mode = 0; mode < 4; mode++) begin
      int secs;
      secs = (mode == 0) ? 20 : (mode == 1) ? 130 : 600;
      wr(4'd0, 8'(mode << 1));
      set_time(50, 5);
      wr(4'd0, 8'((mode << 1) | 1));
      b_rep = rep_cnt;
      tick_sec(secs);
      check($sformatf("R5 mode %0d count", mode), rep_cnt - b_rep, exp_rep(50, 5, secs, mode));
    end
    check("R7 reset alarm silent", alm_cnt, 0);

    // R6 staging
    wr(4'd0, 8'h00);
    set_time(0, 3);
    wr(4'd5, 8'd5); wr(4'd6, 8'd3);
    rd(4'd5, v); check("R6 staged sec hidden", v, 'h3F);
    rd(4'd6, v); check("R6 staged min hidden", v, 'hFF);
    wr(4'd7, 8'd0);
    rd(4'd7, v); check("R6 staged mid hidden", v, 'hFF);
    wr(4'd8, 8'd0);
    rd(4'd5, v); check("R6 commit sec", v, 5);
    rd(4'd6, v); check("R6 commit min lo", v, 3);
    rd(4'd7, v); check("R6 commit min mid", v, 0);
    rd(4'd8, v); check("R6 commit min hi", v, 0);

    // R7 alarm match
    wr(4'd0, 8'h01);
    b_alm = alm_cnt;
    tick_sec(4);
    check("R7 before match", alm_cnt - b_alm, 0);
    tick_sec(1);
    check("R7 at match", alm_cnt - b_alm, 1);
    tick_sec(5);
    check("R7 single pulse", alm_cnt - b_alm, 1);

    // R8 wake qualification
    #1 sys_off = 1'b1;
    wr(4'd0, 8'h09);
    wr(4'd1, 8'd0);
    b_wake = wake_cnt; b_rep = rep_cnt;
    tick_sec(8);
    check("R8 alarm wake", wake_cnt - b_wake, 1);
    check("R8 rep count", rep_cnt - b_rep, 8);
    wr(4'd0, 8'h11);
    b_wake = wake_cnt;
    tick_sec(6);
    check("R8 repeat wake", wake_cnt - b_wake, 6);
    @(posedge clk); #1 sys_off = 1'b0;
    b_wake = wake_cnt;
    tick_sec(3);
    check("R8 no wake when on", wake_cnt - b_wake, 0);

    done = 1'b1;
    report();
  end
endmodule